// File: doc/BRIEF.md
# UART Interrupt Identification Encoder

This block sits between the interrupt sources of a serial port and the bus. It takes five pending conditions (a receive line error, received data at the trigger level, a receive character timeout, an empty transmit holding register and a modem-status change). It masks each one with its own enable bit and reports the most urgent survivor as an 8-bit identification value. Driver software reads that value to decide which service routine to run. The same result drives an active-high interrupt request, which a modem-control gate bit can hold off.

Four of the sources arrive already computed from neighbouring logic. The transmit-empty source differs. It is an event, not a level, so this block keeps it as a pending flag of its own. The flag is raised when the holding register becomes empty, or when its interrupt is enabled while the register is already empty. It is dropped when software either reads the identification value while that value names transmit-empty, or writes the holding register.

Top module: `uart_irq_ident`

## Requirements
- R1: With no enabled source pending, `iid_o[3:0]` reads 4'h1 (bit 0 high means nothing pending) and `irq_o` is low.
- R2: A pending source gives bit 0 low, and `iid_o[3:0]` carries its code: line error 4'h6, received data 4'h4, character timeout 4'hC, transmit-empty 4'h2, modem change 4'h0.
- R3: `iid_o[7:6]` is 2'b11 while `fifo_on_i` is 1 and 2'b00 otherwise. `iid_o[5:4]` is always 2'b00.
- R4: `ier_i` bit 0 enables received data and timeout, bit 1 enables transmit-empty, bit 2 enables line error and bit 3 enables modem change. A source whose enable bit is 0 has no effect on `iid_o` or `irq_o`.
- R5: Priority, highest first: line error, received data, character timeout, transmit-empty, modem change.
- R6: The transmit-empty flag is set at a clock edge where `thr_empty_i` is 1 and was 0 at the previous edge. It is also set at an edge where `ier_i[1]` is 1, was 0 at the previous edge, and `thr_empty_i` is 1.
- R7: The flag is cleared at an edge where `thr_wr_i` is 1, or where `iid_rd_i` is 1 while `iid_o[3:0]` is 4'h2. A clear wins over a set at the same edge.
- R8: `irq_o` is 1 exactly when some enabled source is pending and `irq_gate_i` is 1.
- R9: Synchronous reset clears the flag. It also records the previous empty state as 1 and the previous transmit enable as 0, so an empty register held through reset raises no flag.
- R10: Reading the identification value while it names any source other than transmit-empty leaves the transmit-empty flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_err_i | input | 1 | Receive line error pending |
| rx_ready_i | input | 1 | Receive data at trigger level |
| rx_timeout_i | input | 1 | Receive character timeout |
| thr_empty_i | input | 1 | Transmit holding register empty |
| modem_chg_i | input | 1 | Modem status changed |
| ier_i | input | 4 | Interrupt enable bits |
| fifo_on_i | input | 1 | FIFO mode active |
| irq_gate_i | input | 1 | Modem-control interrupt gate |
| iid_rd_i | input | 1 | Identification value read strobe |
| thr_wr_i | input | 1 | Transmit holding register write strobe |
| iid_o | output | 8 | Identification value |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that the inputs are settled, known values at every rising edge once reset is released. They also assume that a read strobe lasts one cycle for each read, so that a read and the state it observes fall in the same cycle. The bench changes every input only on the falling edge and holds it through the next rising edge. Directed phases cover each code, each enable, the edge-triggered set, the clears and the clear-over-set collision. A long pseudo-random phase then mixes all inputs, including simultaneous reads, writes and empty-edge events.

// File: rtl/uart_iid_pkg.sv
package uart_iid_pkg;

    localparam int IER_W  = 4;
    localparam int EN_RX  = 0;
    localparam int EN_TX  = 1;
    localparam int EN_LS  = 2;
    localparam int EN_MS  = 3;
    localparam int IID_W  = 8;

    typedef enum logic [3:0] {
        ID_MODEM = 4'h0,
        ID_NONE  = 4'h1,
        ID_TXE   = 4'h2,
        ID_RXD   = 4'h4,
        ID_LINE  = 4'h6,
        ID_TMO   = 4'hC
    } iid_code_e;

    typedef struct packed {
        logic line;
        logic rxd;
        logic tmo;
        logic txe;
        logic modem;
    } src_vec_t;

    function automatic logic [IID_W-1:0] pack_iid(iid_code_e c, logic fifo);
        return {{2{fifo}}, 2'b00, c};
    endfunction

endpackage

// File: rtl/uart_thre_pend.sv
module uart_thre_pend (
    input  logic clk,
    input  logic rst,
    input  logic thr_empty_i,
    input  logic tx_en_i,
    input  logic rd_hit_i,
    input  logic thr_wr_i,
    output logic pend_o
);
    logic empty_q;
    logic en_q;
    logic pend_q;
    logic set_ev;
    logic clr_ev;

    always_comb begin
        set_ev = (thr_empty_i && !empty_q) || (tx_en_i && !en_q && thr_empty_i);
        clr_ev = thr_wr_i || rd_hit_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            empty_q <= 1'b1;
            en_q    <= 1'b0;
            pend_q  <= 1'b0;
        end else begin
            empty_q <= thr_empty_i;
            en_q    <= tx_en_i;
            if (clr_ev)
                pend_q <= 1'b0;
            else if (set_ev)
                pend_q <= 1'b1;
        end
    end

    assign pend_o = pend_q;

    AST_EMPTY_EDGE_SETS: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && thr_empty_i && !$past(thr_empty_i) && !thr_wr_i && !rd_hit_i) |=> pend_o) // R6
        else $error("empty edge did not set flag");

    AST_EN_EDGE_SETS: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && thr_empty_i && tx_en_i && !$past(tx_en_i) && !thr_wr_i && !rd_hit_i) |=> pend_o) // R6
        else $error("enable edge did not set flag");

endmodule

// File: rtl/uart_iid_prio.sv
module uart_iid_prio
    import uart_iid_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  src_vec_t             src_i,
    input  logic [IER_W-1:0]     ier_i,
    input  logic                 fifo_on_i,
    output iid_code_e            code_o,
    output logic [IID_W-1:0]     iid_o,
    output logic                 pending_o
);
    src_vec_t live;

    always_comb begin
        live.line  = src_i.line  && ier_i[EN_LS];
        live.rxd   = src_i.rxd   && ier_i[EN_RX];
        live.tmo   = src_i.tmo   && ier_i[EN_RX];
        live.txe   = src_i.txe   && ier_i[EN_TX];
        live.modem = src_i.modem && ier_i[EN_MS];
    end

    always_comb begin
        if (live.line)       code_o = ID_LINE;
        else if (live.rxd)   code_o = ID_RXD;
        else if (live.tmo)   code_o = ID_TMO;
        else if (live.txe)   code_o = ID_TXE;
        else if (live.modem) code_o = ID_MODEM;
        else                 code_o = ID_NONE;
    end

    assign pending_o = (live != '0);
    assign iid_o     = pack_iid(code_o, fifo_on_i);

    AST_FIFO_BITS: assert property (@(posedge clk) disable iff (rst)
        (iid_o[7:6] == {2{fifo_on_i}}) && (iid_o[5:4] == 2'b00)) // R3
        else $error("mode bits wrong");

    AST_LINE_FIRST: assert property (@(posedge clk) disable iff (rst)
        (src_i.line && ier_i[EN_LS]) |-> (iid_o[3:0] == 4'h6)) // R5
        else $error("line error not on top");

    AST_IDLE_CODE: assert property (@(posedge clk) disable iff (rst)
        (ier_i == '0) |-> (iid_o[3:0] == 4'h1)) // R4
        else $error("masked source reported");

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_iid_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        line_err_i,
    input  logic        rx_ready_i,
    input  logic        rx_timeout_i,
    input  logic        thr_empty_i,
    input  logic        modem_chg_i,
    input  logic [3:0]  ier_i,
    input  logic        fifo_on_i,
    input  logic        irq_gate_i,
    input  logic        iid_rd_i,
    input  logic        thr_wr_i,
    output logic [7:0]  iid_o,
    output logic        irq_o
);
    logic      txe_pend;
    logic      rd_hit;
    logic      any_pend;
    iid_code_e cur_code;
    src_vec_t  srcs;

    always_comb begin
        srcs.line  = line_err_i;
        srcs.rxd   = rx_ready_i;
        srcs.tmo   = rx_timeout_i;
        srcs.txe   = txe_pend;
        srcs.modem = modem_chg_i;
    end

    assign rd_hit = iid_rd_i && (cur_code == ID_TXE);

    uart_thre_pend u_pend (
        .clk         (clk),
        .rst         (rst),
        .thr_empty_i (thr_empty_i),
        .tx_en_i     (ier_i[EN_TX]),
        .rd_hit_i    (rd_hit),
        .thr_wr_i    (thr_wr_i),
        .pend_o      (txe_pend)
    );

    uart_iid_prio u_prio (
        .clk       (clk),
        .rst       (rst),
        .src_i     (srcs),
        .ier_i     (ier_i),
        .fifo_on_i (fifo_on_i),
        .code_o    (cur_code),
        .iid_o     (iid_o),
        .pending_o (any_pend)
    );

    assign irq_o = any_pend && irq_gate_i;

    AST_GATE_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
        !irq_gate_i |-> !irq_o) // R8
        else $error("irq without gate");

    AST_IRQ_NEEDS_SOURCE: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> !iid_o[0]) // R1
        else $error("irq with idle id");

    AST_WR_CLEARS: assert property (@(posedge clk) disable iff (rst)
        thr_wr_i |=> !txe_pend) // R7
        else $error("write did not clear flag");

    AST_RD_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (iid_rd_i && iid_o[3:0] == 4'h2) |=> !txe_pend) // R7
        else $error("read did not clear flag");

    AST_OTHER_RD_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (iid_rd_i && iid_o[3:0] != 4'h2 && txe_pend && !thr_wr_i) |=> txe_pend) // R10
        else $error("foreign read dropped flag");

endmodule

// File: tb/uart_irq_ident_bench.sv
`timescale 1ns/1ps
module uart_irq_ident_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       line_err = 0, rx_ready = 0, rx_timeout = 0, thr_empty = 1, modem_chg = 0;
    logic [3:0] ier = 4'h0;
    logic       fifo_on = 0, irq_gate = 0, iid_rd = 0, thr_wr = 0;
    logic [7:0] iid;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    int m_flag, m_prev_e, m_prev_en;

    always #2.5 clk = ~clk;

    uart_irq_ident u_uart_irq_ident (
        .clk(clk), .rst(rst),
        .line_err_i(line_err), .rx_ready_i(rx_ready), .rx_timeout_i(rx_timeout),
        .thr_empty_i(thr_empty), .modem_chg_i(modem_chg), .ier_i(ier),
        .fifo_on_i(fifo_on), .irq_gate_i(irq_gate), .iid_rd_i(iid_rd),
        .thr_wr_i(thr_wr), .iid_o(iid), .irq_o(irq)
    );

    function automatic int exp_code();
        if (line_err && ier[2]) return 6;
        if (rx_ready && ier[0]) return 4;
        if (rx_timeout && ier[0]) return 12;
        if (m_flag != 0 && ier[1]) return 2;
        if (modem_chg && ier[3]) return 0;
        return 1;
    endfunction

    task automatic check(string tag, int act, int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // inputs already driven after a falling edge; compare, then advance model over the rising edge
    task automatic cycle(string tag);
        int c;
        #0.5;
        c = exp_code();
        check(tag, int'(iid[3:0]), c);
        check("R3", int'(iid[7:4]), fifo_on ? 12 : 0);
        check("R8", int'(irq), (c != 1 && irq_gate) ? 1 : 0);
        @(posedge clk);
        begin
            int rise, clr;
            rise = ((thr_empty && m_prev_e == 0) || (ier[1] && m_prev_en == 0 && thr_empty)) ? 1 : 0;
            clr  = (thr_wr || (iid_rd && c == 2)) ? 1 : 0;
            if (clr != 0) m_flag = 0;
            else if (rise != 0) m_flag = 1;
            m_prev_e  = thr_empty ? 1 : 0;
            m_prev_en = ier[1] ? 1 : 0;
        end
        @(negedge clk);
        iid_rd = 0;
        thr_wr = 0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        m_flag = 0; m_prev_e = 1; m_prev_en = 0;
        cycle("R9");                       // empty held through reset: no flag
        cycle("R1");
        irq_gate = 1;
        ier = 4'hF;
        cycle("R1");                       // enable edge seen at this edge
        cycle("R6");                       // flag now reports 4'h2
        fifo_on = 1;
        iid_rd = 1;
        cycle("R6");                       // read while 4'h2 shown
        cycle("R7");                       // flag cleared, idle
        thr_empty = 0;
        cycle("R1");
        thr_empty = 1;
        cycle("R1");                       // rising edge sampled here
        cycle("R6");
        line_err = 1; rx_ready = 1; rx_timeout = 1; modem_chg = 1;
        cycle("R5");                       // line error on top
        iid_rd = 1;
        cycle("R10");                      // read of line code keeps flag
        line_err = 0;
        cycle("R5");                       // received data next
        rx_ready = 0;
        cycle("R2");                       // timeout code
        rx_timeout = 0;
        cycle("R10");                      // flag survived: 4'h2
        thr_wr = 1;
        cycle("R7");
        cycle("R2");                       // modem code
        ier = 4'h0; line_err = 1; rx_ready = 1;
        cycle("R4");
        ier = 4'h7;
        cycle("R4");                       // modem masked, line shown
        line_err = 0; rx_ready = 0;
        irq_gate = 0; ier = 4'h8;
        cycle("R8");
        irq_gate = 1; modem_chg = 0; fifo_on = 0;
        thr_empty = 0; ier = 4'h2;
        cycle("R1");
        thr_empty = 1; thr_wr = 1;
        cycle("R7");                       // clear beats rising edge
        cycle("R7");
        for (int i = 0; i < 4000; i++) begin
            line_err   = ($urandom_range(0, 7) == 0);
            rx_ready   = ($urandom_range(0, 5) == 0);
            rx_timeout = ($urandom_range(0, 5) == 0);
            modem_chg  = $urandom_range(0, 1) == 1;
            thr_empty  = $urandom_range(0, 2) != 0;
            ier        = 4'($urandom_range(0, 15));
            fifo_on    = $urandom_range(0, 1) == 1;
            irq_gate   = $urandom_range(0, 3) != 0;
            iid_rd     = $urandom_range(0, 2) == 0;
            thr_wr     = $urandom_range(0, 4) == 0;
            cycle("R5");
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule